// File: doc/BRIEF.md
# Instruction Fetch Cache with Compressed-Halfword Path

This block sits between an instruction fetch stage and the translated memory path. For each accepted fetch address it returns one 32-bit instruction word. Word-aligned fetches are looked up in a small direct-mapped store. A hit answers in one cycle. A miss issues one 32-bit memory read and then writes the word into the indexed entry.

When compressed code is enabled, a fetch at an address that is 2 mod 4 takes a separate path that never uses the store. The block reads the 16-bit halfword at that address. If that halfword is a full-length instruction, it also reads the following halfword and places it in the upper half of the result. Any other fetch that is not word-aligned answers with a misalignment fault. Access faults reported by the memory side pass straight through to the response, together with the address that faulted. A flush input invalidates every entry.

Top module: `ifc_cache`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The block accepts a request only while `req_ready` is 1. After every response `req_ready` is 1 again.
- R2: The store has ENTRIES (32) entries, indexed by address bits [6:2]. A word-aligned fetch whose entry holds the tag (address | 1) is a hit. `rsp_valid` rises the cycle after acceptance with the stored word, and no memory request is made.
- R3: Each entry keeps the full fetch address as its tag, so two word addresses that share an index evict each other. After reset every tag is zero, which means invalid.
- R4: A word-aligned miss issues exactly one memory request with `mem_req_half`=0 at the fetch address. One cycle after `mem_rsp_valid` the block returns `mem_rsp_data` and fills the entry.
- R5: With `req_cmode`=1 and address bits [1:0]=2, the block issues one request with `mem_req_half`=1 at that address. A halfword is compressed when its bits [1:0] are not 2'b11. A compressed halfword returns as {16'h0, half}, one cycle after the memory response.
- R6: If the first halfword is not compressed, the block issues a second halfword request at address+2. The result is {second[15:0], first[15:0]}, returned one cycle after the second response.
- R7: Halfword-path fetches never fill the store, so repeating one issues memory requests again.
- R8: An address with bit 0 set, bits [1:0]=3, or bits [1:0]=2 with `req_cmode`=0 gives `rsp_misaligned`=1 and `rsp_badaddr`=address in the next cycle, with no memory request.
- R9: A memory response with `mem_rsp_fault`=1 gives `rsp_access_fault`=1 one cycle later. `rsp_badaddr` is the faulting request address, and the store is not filled.
- R10: A one-cycle `flush` pulse invalidates every entry, so the next fetch of a previously cached address misses.
- R11: While a miss or halfword fetch is outstanding, `req_ready` is 0 and requests on the request port have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Fetch request |
| req_addr | input | ADDR_W | Fetch address |
| req_cmode | input | 1 | Compressed code enabled |
| req_ready | output | 1 | Block idle, request accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_insn | output | 32 | Instruction word (0 on fault) |
| rsp_misaligned | output | 1 | Misaligned fetch fault |
| rsp_access_fault | output | 1 | Access fault passed through |
| rsp_badaddr | output | ADDR_W | Faulting address |
| mem_req_valid | output | 1 | One-cycle memory read strobe |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_req_half | output | 1 | 1: 16-bit read, 0: 32-bit read |
| mem_rsp_valid | input | 1 | Memory read returned |
| mem_rsp_data | input | 32 | Read data (halfword in [15:0]) |
| mem_rsp_fault | input | 1 | Read faulted |

## Verification
The checker watches the handshake on every cycle. It confirms that a memory request is never made while the block is idle, and that the block is idle whenever it responds. It also checks that memory request addresses are aligned for their size, that odd-address fetches answer with a misalignment fault in the next cycle, and that an access fault appears only right after a faulting memory response. Three behaviours need the bench's scenarios, because they depend on history that no single-cycle property can see: which word an entry holds, eviction between aliasing addresses, and whether a flush or a faulting or halfword fetch leaves the store unfilled. The same holds for the two-halfword assembly order.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int unsigned INSN_W = 32;
    localparam int unsigned HALF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORD,
        ST_LO,
        ST_HI
    } fetch_state_e;

    typedef struct packed {
        logic              valid;
        logic [INSN_W-1:0] insn;
        logic              misal;
        logic              acc;
    } fetch_rsp_t;

    function automatic logic is_compressed(input logic [HALF_W-1:0] h);
        return h[1:0] != 2'b11;
    endfunction
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store
    import ifc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [INSN_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [INSN_W-1:0] wr_data
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [ADDR_W-1:0] tags [ENTRIES];
    logic [INSN_W-1:0] words[ENTRIES];
    logic [IDX_W-1:0]  lk_idx, wr_idx;

    assign lk_idx = lk_addr[IDX_W+1:2];
    assign wr_idx = wr_addr[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '0;
        end else if (wr_en) begin
            tags[wr_idx] <= wr_addr | ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end

    always_comb begin
        lk_hit  = (lk_addr[1:0] == 2'b00) && (tags[lk_idx] == (lk_addr | ADDR_W'(1)));
        lk_data = words[lk_idx];
    end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cmode,
    output logic              req_ready,
    input  logic              lk_hit,
    input  logic [INSN_W-1:0] lk_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output fetch_rsp_t        rsp,
    output logic [ADDR_W-1:0] rsp_badaddr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_half,
    input  logic              mem_rsp_valid,
    input  logic [INSN_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_fault
);
    fetch_state_e      state;
    logic [ADDR_W-1:0] cur_addr;
    logic [HALF_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_addr;

    assign hi_addr   = cur_addr + ADDR_W'(2);
    assign req_ready = (state == ST_IDLE);
    assign wr_en     = (state == ST_WORD) && mem_rsp_valid && !mem_rsp_fault;
    assign wr_addr   = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cur_addr      <= '0;
            lo_q          <= '0;
            rsp           <= '0;
            rsp_badaddr   <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_half  <= 1'b0;
        end else begin
            rsp.valid     <= 1'b0;
            rsp.misal     <= 1'b0;
            rsp.acc       <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    if (req_addr[1:0] == 2'b00) begin
                        if (lk_hit) begin
                            rsp.valid <= 1'b1;
                            rsp.insn  <= lk_data;
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= req_addr;
                            mem_req_half  <= 1'b0;
                            state         <= ST_WORD;
                        end
                    end else if (req_cmode && req_addr[1:0] == 2'b10) begin
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= req_addr;
                        mem_req_half  <= 1'b1;
                        state         <= ST_LO;
                    end else begin
                        rsp.valid   <= 1'b1;
                        rsp.misal   <= 1'b1;
                        rsp.insn    <= '0;
                        rsp_badaddr <= req_addr;
                    end
                end
                ST_WORD: if (mem_rsp_valid) begin
                    rsp.valid <= 1'b1;
                    state     <= ST_IDLE;
                    if (mem_rsp_fault) begin
                        rsp.acc     <= 1'b1;
                        rsp.insn    <= '0;
                        rsp_badaddr <= cur_addr;
                    end else begin
                        rsp.insn <= mem_rsp_data;
                    end
                end
                ST_LO: if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        rsp.valid   <= 1'b1;
                        rsp.acc     <= 1'b1;
                        rsp.insn    <= '0;
                        rsp_badaddr <= cur_addr;
                        state       <= ST_IDLE;
                    end else if (is_compressed(mem_rsp_data[HALF_W-1:0])) begin
                        rsp.valid <= 1'b1;
                        rsp.insn  <= {{(INSN_W-HALF_W){1'b0}}, mem_rsp_data[HALF_W-1:0]};
                        state     <= ST_IDLE;
                    end else begin
                        lo_q          <= mem_rsp_data[HALF_W-1:0];
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= hi_addr;
                        mem_req_half  <= 1'b1;
                        state         <= ST_HI;
                    end
                end
                ST_HI: if (mem_rsp_valid) begin
                    rsp.valid <= 1'b1;
                    state     <= ST_IDLE;
                    if (mem_rsp_fault) begin
                        rsp.acc     <= 1'b1;
                        rsp.insn    <= '0;
                        rsp_badaddr <= hi_addr;
                    end else begin
                        rsp.insn <= {mem_rsp_data[HALF_W-1:0], lo_q};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ifc_cache.sv
module ifc_cache
    import ifc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cmode,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_insn,
    output logic              rsp_misaligned,
    output logic              rsp_access_fault,
    output logic [ADDR_W-1:0] rsp_badaddr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_half,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_fault
);
    logic              lk_hit, wr_en;
    logic [INSN_W-1:0] lk_data;
    logic [ADDR_W-1:0] wr_addr;
    fetch_rsp_t        rsp;

    ifc_tag_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_addr(req_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(mem_rsp_data)
    );

    ifc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmode(req_cmode),
        .req_ready(req_ready),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .rsp(rsp), .rsp_badaddr(rsp_badaddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_half(mem_req_half),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_fault(mem_rsp_fault)
    );

    assign rsp_valid        = rsp.valid;
    assign rsp_insn         = rsp.insn;
    assign rsp_misaligned   = rsp.misal;
    assign rsp_access_fault = rsp.acc;
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_misaligned,
    input logic              rsp_access_fault,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_half,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_fault
);
    a_r1_idle_on_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    a_r11_busy_on_mem_req: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    a_r4_mem_req_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_half ? !mem_req_addr[0] : (mem_req_addr[1:0] == 2'b00)));

    a_r8_odd_is_misaligned: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_addr[0]) |=> (rsp_valid && rsp_misaligned && !mem_req_valid));

    a_r9_fault_follows_mem: assert property (@(posedge clk) disable iff (rst)
        rsp_access_fault |-> $past(mem_rsp_valid && mem_rsp_fault));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        (rsp_misaligned || rsp_access_fault) |-> (rsp_valid && !(rsp_misaligned && rsp_access_fault)));
endmodule

bind ifc_cache ifc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ifc_cache.sv
module tb_ifc_cache;
    localparam logic [31:0] LIM = 32'h0001_0000;
    localparam int LAT = 2;

    logic        clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic        req_valid = 1'b0, req_cmode = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_misaligned, rsp_access_fault;
    logic [31:0] rsp_insn, rsp_badaddr;
    logic        mem_req_valid, mem_req_half;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_fault = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    ifc_cache dut (.*);

    int n_cmp = 0, n_bad = 0, n_memreq = 0;
    bit done = 0;
    logic [31:0] mtag [32];
    logic [31:0] mdata[32];

    function automatic logic [15:0] hw(input logic [31:0] h);
        return {h[15:5] ^ 11'h5A5, h[4:2], (h[4] ? 2'b11 : 2'b01)};
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] w);
        return {hw(w + 32'd2), hw(w)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder: fixed latency, faults at or above LIM
    logic [31:0] p_addr;
    logic        p_half;
    int          p_cnt = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (p_cnt > 0) begin
            p_cnt--;
            if (p_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_fault = (p_addr >= LIM);
                mem_rsp_data  = p_half ? {16'h0, hw(p_addr)} : word_at(p_addr);
            end
        end
        if (mem_req_valid) begin
            n_memreq++;
            p_addr = mem_req_addr;
            p_half = mem_req_half;
            p_cnt  = LAT;
        end
    end

    task automatic do_fetch(input logic [31:0] a, input logic cm, input bit noisy, input string req);
        int lat, nreq;
        logic [31:0] e_insn, e_bad;
        logic e_mis, e_acc, fill;
        logic [4:0] idx;
        logic [15:0] lo;
        idx = a[6:2];
        e_insn = '0; e_bad = '0; e_mis = 0; e_acc = 0; fill = 0; nreq = 0; lat = 1;
        if (a[1:0] == 2'b00) begin
            if (mtag[idx] == (a | 32'd1)) begin
                e_insn = mdata[idx];
            end else begin
                lat = 2 + LAT; nreq = 1;
                if (a >= LIM) begin e_acc = 1; e_bad = a; end
                else begin e_insn = word_at(a); fill = 1; end
            end
        end else if (cm && a[1:0] == 2'b10) begin
            lat = 2 + LAT; nreq = 1; lo = hw(a);
            if (a >= LIM) begin e_acc = 1; e_bad = a; end
            else if (lo[1:0] != 2'b11) e_insn = {16'h0, lo};
            else begin
                lat = 5 + LAT; nreq = 2;
                if (a + 32'd2 >= LIM) begin e_acc = 1; e_bad = a + 32'd2; end
                else e_insn = {hw(a + 32'd2), lo};
            end
        end else begin
            e_mis = 1; e_bad = a;
        end
        n_memreq = 0;
        req_valid = 1'b1; req_addr = a; req_cmode = cm;
        @(negedge clk);
        req_valid = noisy && (lat > 1);
        req_addr  = a ^ 32'h0000_0044;
        for (int k = 1; k <= 40; k++) begin
            chk(rsp_valid == (k == lat), {req, " rsp_valid timing"}, {31'h0, rsp_valid}, k);
            if (k == lat) break;
            chk(req_ready == 1'b0, "R11 busy ready", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            if (k == 40) chk(0, {req, " response timeout"}, 32'h0, lat);
        end
        req_valid = 1'b0;
        chk(rsp_insn == e_insn, {req, " insn"}, rsp_insn, e_insn);
        chk(rsp_misaligned == e_mis, {req, " R8 misaligned flag"}, {31'h0, rsp_misaligned}, {31'h0, e_mis});
        chk(rsp_access_fault == e_acc, {req, " R9 access flag"}, {31'h0, rsp_access_fault}, {31'h0, e_acc});
        if (e_mis || e_acc) chk(rsp_badaddr == e_bad, {req, " badaddr"}, rsp_badaddr, e_bad);
        chk(n_memreq == nreq, {req, " memory request count"}, n_memreq, nreq);
        if (fill) begin mtag[idx] = a | 32'd1; mdata[idx] = e_insn; end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 32; i++) mtag[i] = '0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin mtag[i] = '0; mdata[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        // R4 miss then R2 hit
        do_fetch(32'h100, 1'b0, 1'b0, "R4 word miss");
        do_fetch(32'h100, 1'b0, 1'b0, "R2 word hit");
        // R3 aliasing eviction
        do_fetch(32'h180, 1'b1, 1'b0, "R3 alias miss");
        do_fetch(32'h100, 1'b1, 1'b0, "R3 evicted miss");
        do_fetch(32'h180, 1'b1, 1'b0, "R3 alias refetch");
        // R5 / R6 / R7 halfword path
        do_fetch(32'h202, 1'b1, 1'b0, "R5 compressed half");
        do_fetch(32'h212, 1'b1, 1'b0, "R6 two halves");
        do_fetch(32'h212, 1'b1, 1'b0, "R7 half not cached");
        do_fetch(32'h202, 1'b1, 1'b0, "R7 compressed not cached");
        // R8 misaligned
        do_fetch(32'h202, 1'b0, 1'b0, "R8 half without cmode");
        do_fetch(32'h101, 1'b1, 1'b0, "R8 odd address");
        do_fetch(32'h103, 1'b0, 1'b0, "R8 addr mod 4 is 3");
        // R9 access faults
        do_fetch(LIM, 1'b0, 1'b0, "R9 word fault");
        do_fetch(LIM, 1'b0, 1'b0, "R9 fault not filled");
        do_fetch(32'h0000_FFFE, 1'b1, 1'b0, "R9 second half fault");
        do_fetch(LIM + 32'd2, 1'b1, 1'b0, "R9 first half fault");
        // R10 flush
        do_fetch(32'h340, 1'b0, 1'b0, "R10 fill");
        do_fetch(32'h340, 1'b0, 1'b0, "R10 hit before flush");
        do_flush();
        do_fetch(32'h340, 1'b0, 1'b0, "R10 miss after flush");
        do_fetch(32'h180, 1'b0, 1'b0, "R10 other entry cleared");
        // R11 requests ignored while busy
        do_fetch(32'h400, 1'b0, 1'b1, "R11 noisy word miss");
        do_fetch(32'h212, 1'b1, 1'b1, "R11 noisy two halves");
        do_fetch(32'h400, 1'b0, 1'b0, "R11 hit after noise");
        do_fetch(32'h444, 1'b0, 1'b0, "R11 noise address not filled");
        // mixed pattern
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = ((i * 37) & 32'h3FC) | (i % 4);
            do_fetch(a, (i % 3) != 0, (i % 5) == 0, "R2 R4 R5 R6 R8 mixed");
            if (i == 40) do_flush();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule